// File: doc/BRIEF.md
# Compressed Page Walk Cache

This block holds partial translations of a four-level page table so that a page walker can skip the levels it has already resolved after a TLB miss. A 48-bit virtual address is split into four 9-bit table indices above a 12-bit page offset. The deepest cached level that matches comes back one cycle after the lookup is accepted, together with the physical frame of the next table to read.

Storage is compressed by sharing. Each distinct top-level index is stored once, in a small root table. Each distinct second-level index is stored once, in a middle table whose entries point back at their root entry through a short slot number rather than a copy of the root index. Every middle entry owns one fixed block of leaf entries, so a leaf entry's whole upper path is implied by the block it lives in. A parameter builds the leaf blocks either direct-mapped or fully associative within the block.

The walker writes results through a fill port, one level per fill. An invalidate-all input empties the cache in one cycle.

Top module: `pwc_compact`

## Requirements
- R1: The address fields are L4 = bits 47:39, L3 = bits 38:30 and L2 = bits 29:21. A lookup is accepted on a clock edge where `lk_valid` and `lk_ready` are both high. On the next cycle `res_valid` is high, and it is low after any cycle with no accepted lookup.
- R2: `res_level` reports the deepest hit. 3 means L2 hit and `res_pfn` is the L1 table frame. 2 means L3 hit and gives the L2 table frame. 1 means L4 hit only and gives the L3 table frame. 0 means miss, with `res_pfn` = 0. An L3 entry only hits under a hitting L4 entry, and an L2 entry only under a hitting L3 entry.
- R3: Filling an L4 index that is already cached rewrites its frame in place. It uses no new slot and keeps the L3 and L2 entries below it.
- R4: The L4 table has 4 entries and the L3 table has 8. An entry is allocated only for a value not yet cached, in round-robin slot order starting at slot 0.
- R5: Allocating an L4 slot invalidates every L3 entry that pointed at the old occupant of that slot.
- R6: Allocating an L3 slot empties the L2 block owned by that slot.
- R7: In direct-mapped mode, bits 2:0 of the L2 index select the entry within the block. Two L2 indices that share those bits replace each other.
- R8: In set-associative mode, one block holds any 8 distinct L2 indices. A new index then replaces the block's entries in round-robin order.
- R9: Addresses with equal L4 and L3 indices but different L2 indices all resolve through one L4 entry and one L3 entry, and each keeps its own L1 table frame.
- R10: `fill_level` is 1 for an L4 entry (value: L3 table frame), 2 for an L3 entry (L2 table frame), 3 for an L2 entry (L1 table frame), and 0 does nothing. An L3 or L2 fill whose parent path is not cached changes nothing.
- R11: With `inv_all` high, `lk_ready` is low, a fill in that cycle is ignored, and every entry and replacement pointer is cleared at the edge.
- R12: When a lookup and a fill share a cycle, the lookup result reflects the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_va | input | 48 | Virtual address to look up |
| fill_valid | input | 1 | Fill request |
| fill_level | input | 2 | Level being filled (1, 2 or 3) |
| fill_va | input | 48 | Address whose indices tag the fill |
| fill_pfn | input | 28 | Next-table frame number to store |
| inv_all | input | 1 | Invalidate all entries |
| res_valid | output | 1 | Lookup result valid |
| res_level | output | 2 | Deepest level hit (0 miss) |
| res_pfn | output | 28 | Frame of the next table to walk |

## Verification
Every cycle, the assertions check the following. Root tags never repeat among valid entries. A middle hit never appears without a root hit, and a leaf hit never without a middle hit. Children are gone one cycle after a root slot is reused, and a block is empty one cycle after its owner is replaced. A fill without a parent leaves the valid bits unchanged. Invalidation empties the root table. The result handshake follows accepted lookups, and a miss carries a zero frame. Only the directed scenarios can show the rest: round-robin victim order, in-place refill keeping children alive, the direct-mapped versus associative conflict behaviour, address field extraction, and the pre-fill view of a same-cycle lookup, all of which depend on sequences of fills and the exact frames returned.

// File: rtl/pwcc_pkg.sv
package pwcc_pkg;

    // Level codes, shared by the fill port and the lookup result
    typedef enum logic [1:0] {
        LVL_MISS = 2'd0,
        LVL_ROOT = 2'd1,
        LVL_MID  = 2'd2,
        LVL_LEAF = 2'd3
    } pwcc_lvl_e;

endpackage

// File: rtl/pwcc_root_tbl.sv
module pwcc_root_tbl #(
    parameter int unsigned IDX_W = 9,
    parameter int unsigned PFN_W = 28,
    parameter int unsigned N_ENT = 4,
    localparam int unsigned SLOT_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [IDX_W-1:0]  lk_idx_i,
    output logic              lk_hit_o,
    output logic [SLOT_W-1:0] lk_slot_o,
    output logic [PFN_W-1:0]  lk_pfn_o,
    input  logic [IDX_W-1:0]  fl_idx_i,
    output logic              fl_hit_o,
    output logic [SLOT_W-1:0] fl_slot_o,
    input  logic              wr_en_i,
    input  logic [PFN_W-1:0]  wr_pfn_i,
    output logic              evict_o,
    output logic [SLOT_W-1:0] evict_slot_o
);

    typedef struct packed {
        logic [N_ENT-1:0]             vld;
        logic [N_ENT-1:0][IDX_W-1:0]  tag;
        logic [N_ENT-1:0][PFN_W-1:0]  pfn;
        logic [SLOT_W-1:0]            rr;
    } root_st_t;

    root_st_t st_d, st_q;

    always_comb begin
        lk_hit_o  = 1'b0;
        lk_slot_o = '0;
        fl_hit_o  = 1'b0;
        fl_slot_o = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (st_q.vld[i] && st_q.tag[i] == lk_idx_i) begin
                lk_hit_o  = 1'b1;
                lk_slot_o = SLOT_W'(i);
            end
            if (st_q.vld[i] && st_q.tag[i] == fl_idx_i) begin
                fl_hit_o  = 1'b1;
                fl_slot_o = SLOT_W'(i);
            end
        end
    end

    assign lk_pfn_o = lk_hit_o ? st_q.pfn[lk_slot_o] : '0;

    always_comb begin
        st_d         = st_q;
        evict_o      = 1'b0;
        evict_slot_o = st_q.rr;
        if (flush_i) begin
            st_d.vld = '0;
            st_d.rr  = '0;
        end else if (wr_en_i) begin
            if (fl_hit_o) begin
                st_d.pfn[fl_slot_o] = wr_pfn_i;
            end else begin
                st_d.vld[st_q.rr] = 1'b1;
                st_d.tag[st_q.rr] = fl_idx_i;
                st_d.pfn[st_q.rr] = wr_pfn_i;
                st_d.rr = (st_q.rr == SLOT_W'(N_ENT - 1)) ? '0 : st_q.rr + 1'b1;
                evict_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic dup_tag;
    always_comb begin
        dup_tag = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            for (int j = i + 1; j < N_ENT; j++) begin
                if (st_q.vld[i] && st_q.vld[j] && st_q.tag[i] == st_q.tag[j]) dup_tag = 1'b1;
            end
        end
    end

    // R3
    root_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup_tag);

    // R11
    root_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.vld == '0));

endmodule

// File: rtl/pwcc_mid_tbl.sv
module pwcc_mid_tbl #(
    parameter int unsigned IDX_W = 9,
    parameter int unsigned PFN_W = 28,
    parameter int unsigned N_ENT = 8,
    parameter int unsigned PAR_W = 2,
    localparam int unsigned SLOT_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [IDX_W-1:0]  lk_idx_i,
    input  logic              lk_par_hit_i,
    input  logic [PAR_W-1:0]  lk_par_i,
    output logic              lk_hit_o,
    output logic [SLOT_W-1:0] lk_slot_o,
    output logic [PFN_W-1:0]  lk_pfn_o,
    input  logic [IDX_W-1:0]  fl_idx_i,
    input  logic              fl_par_hit_i,
    input  logic [PAR_W-1:0]  fl_par_i,
    output logic              fl_hit_o,
    output logic [SLOT_W-1:0] fl_slot_o,
    input  logic              wr_en_i,
    input  logic [PFN_W-1:0]  wr_pfn_i,
    input  logic              kill_en_i,
    input  logic [PAR_W-1:0]  kill_par_i,
    output logic              evict_o,
    output logic [SLOT_W-1:0] evict_slot_o
);

    typedef struct packed {
        logic [N_ENT-1:0]             vld;
        logic [N_ENT-1:0][IDX_W-1:0]  tag;
        logic [N_ENT-1:0][PAR_W-1:0]  par;
        logic [N_ENT-1:0][PFN_W-1:0]  pfn;
        logic [SLOT_W-1:0]            rr;
    } mid_st_t;

    mid_st_t st_d, st_q;

    always_comb begin
        lk_hit_o  = 1'b0;
        lk_slot_o = '0;
        fl_hit_o  = 1'b0;
        fl_slot_o = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (lk_par_hit_i && st_q.vld[i] && st_q.tag[i] == lk_idx_i && st_q.par[i] == lk_par_i) begin
                lk_hit_o  = 1'b1;
                lk_slot_o = SLOT_W'(i);
            end
            if (fl_par_hit_i && st_q.vld[i] && st_q.tag[i] == fl_idx_i && st_q.par[i] == fl_par_i) begin
                fl_hit_o  = 1'b1;
                fl_slot_o = SLOT_W'(i);
            end
        end
    end

    assign lk_pfn_o = lk_hit_o ? st_q.pfn[lk_slot_o] : '0;

    always_comb begin
        st_d         = st_q;
        evict_o      = 1'b0;
        evict_slot_o = st_q.rr;
        if (flush_i) begin
            st_d.vld = '0;
            st_d.rr  = '0;
        end else if (kill_en_i) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (st_q.par[i] == kill_par_i) st_d.vld[i] = 1'b0;
            end
        end else if (wr_en_i && fl_par_hit_i) begin
            if (fl_hit_o) begin
                st_d.pfn[fl_slot_o] = wr_pfn_i;
            end else begin
                st_d.vld[st_q.rr] = 1'b1;
                st_d.tag[st_q.rr] = fl_idx_i;
                st_d.par[st_q.rr] = fl_par_i;
                st_d.pfn[st_q.rr] = wr_pfn_i;
                st_d.rr = (st_q.rr == SLOT_W'(N_ENT - 1)) ? '0 : st_q.rr + 1'b1;
                evict_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_kill_chk
        // R5
        mid_child_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (kill_en_i && st_q.par[g] == kill_par_i) |=> !st_q.vld[g]);
    end

    // R10
    mid_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !fl_par_hit_i && !flush_i && !kill_en_i) |=> $stable(st_q.vld));

endmodule

// File: rtl/pwcc_leaf_blk.sv
module pwcc_leaf_blk #(
    parameter int unsigned IDX_W     = 9,
    parameter int unsigned PFN_W     = 28,
    parameter int unsigned N_BLK     = 8,
    parameter int unsigned BLK_ENT   = 8,
    parameter bit          SET_ASSOC = 1'b0,
    localparam int unsigned BLK_W = $clog2(N_BLK),
    localparam int unsigned WAY_W = $clog2(BLK_ENT),
    localparam int unsigned TAG_W = SET_ASSOC ? IDX_W : IDX_W - WAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [IDX_W-1:0] lk_idx_i,
    input  logic             lk_blk_hit_i,
    input  logic [BLK_W-1:0] lk_blk_i,
    output logic             lk_hit_o,
    output logic [PFN_W-1:0] lk_pfn_o,
    input  logic [IDX_W-1:0] fl_idx_i,
    input  logic             fl_blk_hit_i,
    input  logic [BLK_W-1:0] fl_blk_i,
    input  logic             wr_en_i,
    input  logic [PFN_W-1:0] wr_pfn_i,
    input  logic             clr_en_i,
    input  logic [BLK_W-1:0] clr_blk_i
);

    typedef struct packed {
        logic [N_BLK-1:0][BLK_ENT-1:0]             vld;
        logic [N_BLK-1:0][BLK_ENT-1:0][TAG_W-1:0]  tag;
        logic [N_BLK-1:0][BLK_ENT-1:0][PFN_W-1:0]  pfn;
        logic [N_BLK-1:0][WAY_W-1:0]               rr;
    } leaf_st_t;

    leaf_st_t st_d, st_q;

    logic [TAG_W-1:0] lk_tag, wr_tag;
    logic [WAY_W-1:0] lk_way, wr_way;
    logic             lk_hit_w, wr_alloc;

    assign lk_tag = TAG_W'(lk_idx_i >> (IDX_W - TAG_W));
    assign wr_tag = TAG_W'(fl_idx_i >> (IDX_W - TAG_W));

    if (SET_ASSOC) begin : g_assoc
        logic             fl_hit;
        logic [WAY_W-1:0] fl_way;
        always_comb begin
            lk_hit_w = 1'b0;
            lk_way   = '0;
            fl_hit   = 1'b0;
            fl_way   = '0;
            for (int w = 0; w < BLK_ENT; w++) begin
                if (st_q.vld[lk_blk_i][w] && st_q.tag[lk_blk_i][w] == lk_tag) begin
                    lk_hit_w = 1'b1;
                    lk_way   = WAY_W'(w);
                end
                if (st_q.vld[fl_blk_i][w] && st_q.tag[fl_blk_i][w] == wr_tag) begin
                    fl_hit = 1'b1;
                    fl_way = WAY_W'(w);
                end
            end
            wr_way   = fl_hit ? fl_way : st_q.rr[fl_blk_i];
            wr_alloc = !fl_hit;
        end
    end else begin : g_direct
        always_comb begin
            lk_way   = lk_idx_i[WAY_W-1:0];
            lk_hit_w = st_q.vld[lk_blk_i][lk_way] && st_q.tag[lk_blk_i][lk_way] == lk_tag;
            wr_way   = fl_idx_i[WAY_W-1:0];
            wr_alloc = 1'b0;
        end
    end

    assign lk_hit_o = lk_blk_hit_i && lk_hit_w;
    assign lk_pfn_o = lk_hit_o ? st_q.pfn[lk_blk_i][lk_way] : '0;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.vld = '0;
            st_d.rr  = '0;
        end else if (clr_en_i) begin
            st_d.vld[clr_blk_i] = '0;
            st_d.rr[clr_blk_i]  = '0;
        end else if (wr_en_i && fl_blk_hit_i) begin
            st_d.vld[fl_blk_i][wr_way] = 1'b1;
            st_d.tag[fl_blk_i][wr_way] = wr_tag;
            st_d.pfn[fl_blk_i][wr_way] = wr_pfn_i;
            if (wr_alloc) begin
                st_d.rr[fl_blk_i] = (st_q.rr[fl_blk_i] == WAY_W'(BLK_ENT - 1)) ? '0
                                  : st_q.rr[fl_blk_i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar b = 0; b < N_BLK; b++) begin : g_clr_chk
        // R6
        leaf_block_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en_i && !flush_i && clr_blk_i == BLK_W'(b)) |=> (st_q.vld[b] == '0));
    end

    // R10
    leaf_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !fl_blk_hit_i && !flush_i && !clr_en_i) |=> $stable(st_q.vld));

endmodule

// File: rtl/pwc_compact.sv
module pwc_compact
    import pwcc_pkg::*;
#(
    parameter int unsigned IDX_W     = 9,
    parameter int unsigned OFS_W     = 12,
    parameter int unsigned PFN_W     = 28,
    parameter int unsigned ROOT_ENT  = 4,
    parameter int unsigned MID_ENT   = 8,
    parameter int unsigned LEAF_WAYS = 8,
    parameter bit          SET_ASSOC = 1'b0,
    localparam int unsigned VA_W   = OFS_W + 4 * IDX_W,
    localparam int unsigned L4_LSB = OFS_W + 3 * IDX_W,
    localparam int unsigned L3_LSB = OFS_W + 2 * IDX_W,
    localparam int unsigned L2_LSB = OFS_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    output logic             lk_ready,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             fill_valid,
    input  logic [1:0]       fill_level,
    input  logic [VA_W-1:0]  fill_va,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             inv_all,
    output logic             res_valid,
    output logic [1:0]       res_level,
    output logic [PFN_W-1:0] res_pfn
);

    localparam int unsigned ROOT_SW = $clog2(ROOT_ENT);
    localparam int unsigned MID_SW  = $clog2(MID_ENT);

    typedef struct packed {
        logic             vld;
        pwcc_lvl_e        lvl;
        logic [PFN_W-1:0] pfn;
    } res_t;

    res_t res_d, res_q;

    logic [IDX_W-1:0] lk_l4, lk_l3, lk_l2, fl_l4, fl_l3, fl_l2;
    assign lk_l4 = lk_va[L4_LSB +: IDX_W];
    assign lk_l3 = lk_va[L3_LSB +: IDX_W];
    assign lk_l2 = lk_va[L2_LSB +: IDX_W];
    assign fl_l4 = fill_va[L4_LSB +: IDX_W];
    assign fl_l3 = fill_va[L3_LSB +: IDX_W];
    assign fl_l2 = fill_va[L2_LSB +: IDX_W];

    logic unused_va_bits;
    assign unused_va_bits = ^{lk_va[L2_LSB-1:0], fill_va[L2_LSB-1:0]};

    logic fill_go, wr_root, wr_mid, wr_leaf;
    assign fill_go = fill_valid && !inv_all;
    assign wr_root = fill_go && fill_level == LVL_ROOT;
    assign wr_mid  = fill_go && fill_level == LVL_MID;
    assign wr_leaf = fill_go && fill_level == LVL_LEAF;

    logic               root_lk_hit, root_fl_hit, root_evict;
    logic [ROOT_SW-1:0] root_lk_slot, root_fl_slot, root_evict_slot;
    logic [PFN_W-1:0]   root_lk_pfn;

    logic               mid_lk_hit, mid_fl_hit, mid_evict;
    logic [MID_SW-1:0]  mid_lk_slot, mid_fl_slot, mid_evict_slot;
    logic [PFN_W-1:0]   mid_lk_pfn;

    logic               leaf_lk_hit;
    logic [PFN_W-1:0]   leaf_lk_pfn;

    pwcc_root_tbl #(
        .IDX_W(IDX_W), .PFN_W(PFN_W), .N_ENT(ROOT_ENT)
    ) u_root (
        .clk(clk), .rst_n(rst_n), .flush_i(inv_all),
        .lk_idx_i(lk_l4), .lk_hit_o(root_lk_hit), .lk_slot_o(root_lk_slot), .lk_pfn_o(root_lk_pfn),
        .fl_idx_i(fl_l4), .fl_hit_o(root_fl_hit), .fl_slot_o(root_fl_slot),
        .wr_en_i(wr_root), .wr_pfn_i(fill_pfn),
        .evict_o(root_evict), .evict_slot_o(root_evict_slot)
    );

    pwcc_mid_tbl #(
        .IDX_W(IDX_W), .PFN_W(PFN_W), .N_ENT(MID_ENT), .PAR_W(ROOT_SW)
    ) u_mid (
        .clk(clk), .rst_n(rst_n), .flush_i(inv_all),
        .lk_idx_i(lk_l3), .lk_par_hit_i(root_lk_hit), .lk_par_i(root_lk_slot),
        .lk_hit_o(mid_lk_hit), .lk_slot_o(mid_lk_slot), .lk_pfn_o(mid_lk_pfn),
        .fl_idx_i(fl_l3), .fl_par_hit_i(root_fl_hit), .fl_par_i(root_fl_slot),
        .fl_hit_o(mid_fl_hit), .fl_slot_o(mid_fl_slot),
        .wr_en_i(wr_mid), .wr_pfn_i(fill_pfn),
        .kill_en_i(root_evict), .kill_par_i(root_evict_slot),
        .evict_o(mid_evict), .evict_slot_o(mid_evict_slot)
    );

    pwcc_leaf_blk #(
        .IDX_W(IDX_W), .PFN_W(PFN_W), .N_BLK(MID_ENT), .BLK_ENT(LEAF_WAYS), .SET_ASSOC(SET_ASSOC)
    ) u_leaf (
        .clk(clk), .rst_n(rst_n), .flush_i(inv_all),
        .lk_idx_i(lk_l2), .lk_blk_hit_i(mid_lk_hit), .lk_blk_i(mid_lk_slot),
        .lk_hit_o(leaf_lk_hit), .lk_pfn_o(leaf_lk_pfn),
        .fl_idx_i(fl_l2), .fl_blk_hit_i(mid_fl_hit), .fl_blk_i(mid_fl_slot),
        .wr_en_i(wr_leaf), .wr_pfn_i(fill_pfn),
        .clr_en_i(mid_evict), .clr_blk_i(mid_evict_slot)
    );

    assign lk_ready = !inv_all;

    logic accept;
    assign accept = lk_valid && lk_ready;

    always_comb begin
        res_d     = '0;
        res_d.vld = accept;
        if (accept) begin
            if (leaf_lk_hit) begin
                res_d.lvl = LVL_LEAF;
                res_d.pfn = leaf_lk_pfn;
            end else if (mid_lk_hit) begin
                res_d.lvl = LVL_MID;
                res_d.pfn = mid_lk_pfn;
            end else if (root_lk_hit) begin
                res_d.lvl = LVL_ROOT;
                res_d.pfn = root_lk_pfn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.vld;
    assign res_level = res_q.lvl;
    assign res_pfn   = res_q.pfn;

    // R1
    res_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> res_valid);

    // R1
    res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !res_valid);

    // R2
    mid_needs_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid_lk_hit |-> root_lk_hit);

    // R2
    leaf_needs_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        leaf_lk_hit |-> mid_lk_hit);

    // R2
    miss_zero_pfn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_level == LVL_MISS) |-> (res_pfn == '0));

    // R11
    inv_blocks_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !res_valid);

endmodule

// File: tb/test_pwc_compact.sv
module test_pwc_compact;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_va = '0;
    logic        fill_valid = 1'b0;
    logic [1:0]  fill_level = '0;
    logic [47:0] fill_va = '0;
    logic [27:0] fill_pfn = '0;
    logic        inv_all = 1'b0;

    logic        dm_ready, dm_vld, sa_ready, sa_vld;
    logic [1:0]  dm_lvl, sa_lvl;
    logic [27:0] dm_pfn, sa_pfn;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwc_compact #(.SET_ASSOC(1'b0)) i_pwc_compact (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(dm_ready), .lk_va(lk_va),
        .fill_valid(fill_valid), .fill_level(fill_level), .fill_va(fill_va), .fill_pfn(fill_pfn),
        .inv_all(inv_all), .res_valid(dm_vld), .res_level(dm_lvl), .res_pfn(dm_pfn)
    );

    pwc_compact #(.SET_ASSOC(1'b1)) i_pwc_compact_sa (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(sa_ready), .lk_va(lk_va),
        .fill_valid(fill_valid), .fill_level(fill_level), .fill_va(fill_va), .fill_pfn(fill_pfn),
        .inv_all(inv_all), .res_valid(sa_vld), .res_level(sa_lvl), .res_pfn(sa_pfn)
    );

    function automatic logic [47:0] mkva(input logic [8:0] a, input logic [8:0] b, input logic [8:0] c);
        return {a, b, c, 9'h000, 12'h000};
    endfunction

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic look2(input logic [47:0] va, input logic [1:0] el, input logic [27:0] ep,
                         input logic [1:0] el_sa, input logic [27:0] ep_sa, input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_va    = va;
        @(negedge clk);
        lk_valid = 1'b0;
        cmp(req, "direct", {1'b0, dm_vld, dm_lvl, dm_pfn}, {1'b0, 1'b1, el, ep});
        cmp(req, "assoc",  {1'b0, sa_vld, sa_lvl, sa_pfn}, {1'b0, 1'b1, el_sa, ep_sa});
    endtask

    task automatic look(input logic [47:0] va, input logic [1:0] el, input logic [27:0] ep, input string req);
        look2(va, el, ep, el, ep, req);
    endtask

    task automatic fill(input logic [1:0] lvl, input logic [47:0] va, input logic [27:0] pfn);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_level = lvl;
        fill_va    = va;
        fill_pfn   = pfn;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    task automatic t_reset();
        cmp("R1", "valid after reset", {30'd0, dm_vld, sa_vld}, 32'd0);
        cmp("R11", "ready after reset", {30'd0, dm_ready, sa_ready}, 32'd3);
        look(mkva(9'h0ff, 9'h143, 9'h000), 2'd0, 28'h0, "R2");
    endtask

    task automatic t_split_share();
        fill(2'd1, mkva(9'h0ff, 9'h000, 9'h000), 28'h00000a1);
        fill(2'd2, mkva(9'h0ff, 9'h143, 9'h000), 28'h00000b1);
        fill(2'd3, mkva(9'h0ff, 9'h143, 9'h000), 28'h00000c0);
        fill(2'd3, mkva(9'h0ff, 9'h143, 9'h001), 28'h00000c1);
        fill(2'd3, mkva(9'h0ff, 9'h143, 9'h002), 28'h00000c2);
        look(48'h7fd0c00714c0, 2'd3, 28'h00000c0, "R1");
        look(48'h7fd0c0072190, 2'd3, 28'h00000c0, "R9");
        look(48'h7fd0c02a8bf0, 2'd3, 28'h00000c1, "R9");
        look(48'h7fd10e0cdee0, 2'd1, 28'h00000a1, "R2");
        look(48'h7f734dc110df, 2'd0, 28'h0, "R2");
        look(mkva(9'h0ff, 9'h143, 9'h005), 2'd2, 28'h00000b1, "R2");
        // refill of a cached root index: in place, children kept
        fill(2'd1, mkva(9'h0ff, 9'h000, 9'h000), 28'h00000a2);
        look(mkva(9'h0ff, 9'h143, 9'h002), 2'd3, 28'h00000c2, "R3");
        look(mkva(9'h0ff, 9'h144, 9'h002), 2'd1, 28'h00000a2, "R3");
        fill(2'd1, mkva(9'h001, 9'h0, 9'h0), 28'h0000011);
        fill(2'd1, mkva(9'h002, 9'h0, 9'h0), 28'h0000012);
        fill(2'd1, mkva(9'h003, 9'h0, 9'h0), 28'h0000013);
        look(mkva(9'h0ff, 9'h143, 9'h002), 2'd3, 28'h00000c2, "R3");
    endtask

    task automatic t_root_evict();
        flush();
        fill(2'd1, mkva(9'h010, 9'h0, 9'h0), 28'h0000310);
        fill(2'd1, mkva(9'h011, 9'h0, 9'h0), 28'h0000311);
        fill(2'd1, mkva(9'h012, 9'h0, 9'h0), 28'h0000312);
        fill(2'd1, mkva(9'h013, 9'h0, 9'h0), 28'h0000313);
        fill(2'd2, mkva(9'h010, 9'h020, 9'h0), 28'h0000320);
        look(mkva(9'h010, 9'h020, 9'h0), 2'd2, 28'h0000320, "R4");
        fill(2'd1, mkva(9'h014, 9'h0, 9'h0), 28'h0000314);
        look(mkva(9'h010, 9'h020, 9'h0), 2'd0, 28'h0, "R4");
        look(mkva(9'h014, 9'h020, 9'h0), 2'd1, 28'h0000314, "R4");
        look(mkva(9'h011, 9'h020, 9'h0), 2'd1, 28'h0000311, "R4");
        fill(2'd1, mkva(9'h015, 9'h0, 9'h0), 28'h0000315);
        fill(2'd1, mkva(9'h016, 9'h0, 9'h0), 28'h0000316);
        fill(2'd1, mkva(9'h017, 9'h0, 9'h0), 28'h0000317);
        fill(2'd1, mkva(9'h010, 9'h0, 9'h0), 28'h0000330);
        // same slot as before, but the old child must be gone
        look(mkva(9'h010, 9'h020, 9'h0), 2'd1, 28'h0000330, "R5");
        look(mkva(9'h011, 9'h020, 9'h0), 2'd0, 28'h0, "R4");
    endtask

    task automatic t_mid_evict();
        flush();
        fill(2'd1, mkva(9'h001, 9'h0, 9'h0), 28'h0000401);
        for (int k = 0; k < 8; k++) begin
            fill(2'd2, mkva(9'h001, 9'(9'h100 + k), 9'h0), 28'(28'h0000500 + k));
        end
        fill(2'd3, mkva(9'h001, 9'h100, 9'h005), 28'h0000600);
        look(mkva(9'h001, 9'h100, 9'h005), 2'd3, 28'h0000600, "R9");
        fill(2'd2, mkva(9'h001, 9'h108, 9'h0), 28'h0000508);
        look(mkva(9'h001, 9'h100, 9'h005), 2'd1, 28'h0000401, "R4");
        look(mkva(9'h001, 9'h108, 9'h005), 2'd2, 28'h0000508, "R6");
        look(mkva(9'h001, 9'h101, 9'h000), 2'd2, 28'h0000501, "R4");
    endtask

    task automatic t_modes();
        flush();
        fill(2'd1, mkva(9'h0ff, 9'h0, 9'h0), 28'h0000701);
        fill(2'd2, mkva(9'h0ff, 9'h143, 9'h0), 28'h0000702);
        fill(2'd3, mkva(9'h0ff, 9'h143, 9'h008), 28'h0000708);
        fill(2'd3, mkva(9'h0ff, 9'h143, 9'h010), 28'h0000710);
        look2(mkva(9'h0ff, 9'h143, 9'h008), 2'd2, 28'h0000702, 2'd3, 28'h0000708, "R7");
        look(mkva(9'h0ff, 9'h143, 9'h010), 2'd3, 28'h0000710, "R7");
        for (int k = 1; k < 7; k++) begin
            fill(2'd3, mkva(9'h0ff, 9'h143, 9'(k)), 28'(28'h0000720 + k));
        end
        fill(2'd3, mkva(9'h0ff, 9'h143, 9'h007), 28'h0000727);
        look(mkva(9'h0ff, 9'h143, 9'h008), 2'd2, 28'h0000702, "R8");
        look(mkva(9'h0ff, 9'h143, 9'h010), 2'd3, 28'h0000710, "R8");
        look(mkva(9'h0ff, 9'h143, 9'h007), 2'd3, 28'h0000727, "R8");
        look(mkva(9'h0ff, 9'h143, 9'h001), 2'd3, 28'h0000721, "R8");
    endtask

    task automatic t_orphan();
        flush();
        fill(2'd2, mkva(9'h0aa, 9'h0bb, 9'h0), 28'h0000801);
        fill(2'd1, mkva(9'h0aa, 9'h0, 9'h0), 28'h0000802);
        look(mkva(9'h0aa, 9'h0bb, 9'h003), 2'd1, 28'h0000802, "R10");
        fill(2'd3, mkva(9'h0aa, 9'h0cc, 9'h003), 28'h0000803);
        fill(2'd2, mkva(9'h0aa, 9'h0cc, 9'h0), 28'h0000804);
        look(mkva(9'h0aa, 9'h0cc, 9'h003), 2'd2, 28'h0000804, "R10");
        fill(2'd0, mkva(9'h0aa, 9'h0cc, 9'h003), 28'h0000805);
        look(mkva(9'h0aa, 9'h0cc, 9'h003), 2'd2, 28'h0000804, "R10");
    endtask

    task automatic t_flush();
        fill(2'd1, mkva(9'h055, 9'h0, 9'h0), 28'h0000901);
        @(negedge clk);
        inv_all    = 1'b1;
        lk_valid   = 1'b1;
        lk_va      = mkva(9'h055, 9'h0, 9'h0);
        fill_valid = 1'b1;
        fill_level = 2'd1;
        fill_va    = mkva(9'h066, 9'h0, 9'h0);
        fill_pfn   = 28'h0000902;
        #1;
        cmp("R11", "ready during flush", {30'd0, dm_ready, sa_ready}, 32'd0);
        @(negedge clk);
        inv_all    = 1'b0;
        lk_valid   = 1'b0;
        fill_valid = 1'b0;
        cmp("R11", "no result for blocked lookup", {30'd0, dm_vld, sa_vld}, 32'd0);
        look(mkva(9'h055, 9'h0, 9'h0), 2'd0, 28'h0, "R11");
        look(mkva(9'h066, 9'h0, 9'h0), 2'd0, 28'h0, "R11");
    endtask

    task automatic t_same_cycle();
        flush();
        @(negedge clk);
        fill_valid = 1'b1;
        fill_level = 2'd1;
        fill_va    = mkva(9'h077, 9'h0, 9'h0);
        fill_pfn   = 28'h0000a01;
        lk_valid   = 1'b1;
        lk_va      = mkva(9'h077, 9'h001, 9'h0);
        @(negedge clk);
        fill_valid = 1'b0;
        lk_valid   = 1'b0;
        cmp("R12", "direct", {1'b0, dm_vld, dm_lvl, dm_pfn}, {1'b0, 1'b1, 2'd0, 28'h0});
        cmp("R12", "assoc",  {1'b0, sa_vld, sa_lvl, sa_pfn}, {1'b0, 1'b1, 2'd0, 28'h0});
        look(mkva(9'h077, 9'h001, 9'h0), 2'd1, 28'h0000a01, "R12");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_split_share();
        t_root_evict();
        t_mid_evict();
        t_modes();
        t_orphan();
        t_flush();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule